// File: doc/BRIEF.md
# Half-Duplex Control-Response Serial Master

This block runs one serial frame of the command-then-reply kind. It first sends an 8-bit control word to an external slave, most significant bit first, and ignores the receive line while doing so. It then leaves one idle serial clock for the slave to turn the line around. After that it clocks in a reply of 4 to 16 bits, also most significant bit first. While idle, the serial clock is low, the active-low select is high and the data output is low. The serial clock runs at the system clock divided by an even factor. The divider and the reply length are taken when a command is accepted.

The command side is a valid/ready handshake. `cmd_ready` is high only while no frame is running. A command is taken on the first system clock edge where `cmd_valid` and `cmd_ready` are both high. An upstream source that wants its command taken must hold `cmd_valid` and the command fields until that edge. A `cmd_valid` seen while the block is busy has no effect and is not remembered. The reply side cannot apply back-pressure. `rsp_valid` is a pulse one system clock long, and a consumer must take `rsp_data` in that cycle. `busy` is a plain status pin.

Top module: `cr_serial_master`

## Requirements
- R1: Out of reset and whenever no frame runs, `ser_clk` is 0, `ser_sel_n` is 1, `ser_out` is 0, `busy` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both 1. From that edge on, `busy` is 1, `cmd_ready` is 0 and `ser_sel_n` is 0. `ser_clk` first rises one half serial period after that edge.
- R3: The half serial period is H = floor(`sclk_div`/2) system clocks, with H = 1 when that quotient is 0. Bit 0 of `sclk_div` is ignored. H is taken at acceptance, so the serial clock period is 2H system clocks.
- R4: `ser_out` carries `cmd_byte[7]` from the acceptance edge. It carries `cmd_byte[6]` down to `cmd_byte[0]` after each of the next seven falling edges of `ser_clk`. The slave samples each bit on a rising edge.
- R5: `ser_in` is not sampled on the first nine rising edges of `ser_clk`. These are the eight control-bit edges and the turnaround edge.
- R6: `ser_out` is 0 from the eighth falling edge of `ser_clk` until the frame ends.
- R7: With reply length N, the frame has exactly 9+N rising edges of `ser_clk`. `ser_in` is sampled on rising edges 10 through 9+N, and the first sample is the most significant reply bit.
- R8: The reply length N is `rsp_len` clamped to the range 4..16 and taken at acceptance. Values below 4 give 4, and values above 16 give 16.
- R9: One half period after the last rising edge, `ser_clk` returns to 0 and `ser_sel_n` to 1, and `busy` drops. In the same cycle `rsp_valid` is 1 for exactly one system clock. `rsp_data` then holds the N reply bits right-aligned, with bits 15..N set to 0. From acceptance to this cycle takes (18+2N)·H system clocks.
- R10: A `cmd_valid` while `busy` is 1 changes neither the running frame nor anything that follows. No second frame starts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (no frame running) |
| cmd_byte | input | 8 | Control word to send |
| rsp_len | input | 5 | Requested reply length in bits (clamped to 4..16) |
| sclk_div | input | 8 | Serial clock divider, even values of 2 or more |
| busy | output | 1 | Frame in progress |
| rsp_valid | output | 1 | One-cycle pulse: reply available |
| rsp_data | output | 16 | Received reply, right-aligned |
| ser_clk | output | 1 | Serial clock, low when idle |
| ser_sel_n | output | 1 | Active-low frame select |
| ser_out | output | 1 | Serial data to slave |
| ser_in | input | 1 | Serial data from slave |

## Verification
The assertions watch these rules on every cycle:
- the idle line levels;
- select held low for the whole of a busy frame;
- the serial clock moving only on half-period ticks;
- the clamped length and divider staying fixed for the length of a frame;
- the data output staying quiet once the command is out;
- the reply pulse lasting a single cycle with its unused upper bits clear.

The following can only be shown by the bench scenarios, which act as the slave:
- the bit order of the command;
- the exact edges on which the reply is sampled, including that the command and turnaround edges are ignored;
- the frame length in system clocks for each divider and reply length;
- the clamping of out-of-range lengths;
- that a request made mid-frame leaves no trace.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cr_half_tick.sv
module cr_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == half_len - DIV_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (at_end)         cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  // R3: the period counter never runs past the latched half period
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_len));
endmodule

// File: rtl/cr_frame_seq.sv
module cr_frame_seq
  import cr_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int RSP_MIN = 4,
  parameter int RSP_MAX = 16,
  parameter int LEN_W   = 5,
  parameter int DIV_W   = 8,
  parameter int HC_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             tick,
  output logic             accept,
  output logic             busy,
  output logic             launch,
  output logic             sample,
  output logic             fin,
  output logic [HC_W-1:0]  hcnt,
  output logic [LEN_W-1:0] nlen,
  output logic [DIV_W-1:0] half_len,
  output logic             sclk,
  output logic             sel_n
);
  localparam int TURN_HALF = 2 * (CMD_W + 1) - 1;

  seq_state_e       state;
  logic [HC_W-1:0]  next_h;
  logic [HC_W-1:0]  last_half;
  logic [HC_W-1:0]  next_clk;
  logic             step;
  logic [LEN_W-1:0] len_clamped;
  logic [DIV_W-1:0] half_raw;

  assign busy   = (state == SEQ_RUN);
  assign accept = cmd_valid && !busy;

  always_comb begin
    if (rsp_len < LEN_W'(RSP_MIN))      len_clamped = LEN_W'(RSP_MIN);
    else if (rsp_len > LEN_W'(RSP_MAX)) len_clamped = LEN_W'(RSP_MAX);
    else                                len_clamped = rsp_len;
  end

  assign half_raw = sclk_div >> 1;

  assign next_h    = hcnt + HC_W'(1);
  assign next_clk  = next_h >> 1;
  assign last_half = HC_W'(TURN_HALF) + HC_W'({nlen, 1'b0});
  assign fin       = busy && tick && (hcnt == last_half);
  assign step      = busy && tick && !fin;
  // falling edges 1..CMD_W move the next command bit (or a trailing zero) out
  assign launch    = step && !next_h[0] && (next_clk <= HC_W'(CMD_W));
  // rising edges after the turnaround clock capture reply bits
  assign sample    = step && next_h[0] && (next_clk >= HC_W'(CMD_W + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      hcnt     <= '0;
      nlen     <= LEN_W'(RSP_MIN);
      half_len <= DIV_W'(1);
      sclk     <= 1'b0;
      sel_n    <= 1'b1;
    end else if (accept) begin
      state    <= SEQ_RUN;
      hcnt     <= '0;
      nlen     <= len_clamped;
      half_len <= (half_raw == '0) ? DIV_W'(1) : half_raw;
      sclk     <= 1'b0;
      sel_n    <= 1'b0;
    end else if (fin) begin
      state    <= SEQ_IDLE;
      sclk     <= 1'b0;
      sel_n    <= 1'b1;
    end else if (step) begin
      hcnt     <= next_h;
      sclk     <= next_h[0];
    end
  end

  assert_sel_low_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sel_n);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && sel_n));
  assert_sclk_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));
  assert_len_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nlen >= LEN_W'(RSP_MIN) && nlen <= LEN_W'(RSP_MAX)));
  assert_settings_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> ($stable(nlen) && $stable(half_len) && busy));
endmodule

// File: rtl/cr_cmd_shifter.sv
module cr_cmd_shifter #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd,
  input  logic             shift,
  input  logic             clear,
  output logic             sdo
);
  logic [CMD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else if (load) begin
      sdo  <= cmd[CMD_W-1];
      sreg <= cmd << 1;
    end else if (clear) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else if (shift) begin
      sdo  <= sreg[CMD_W-1];
      sreg <= sreg << 1;
    end
  end
endmodule

// File: rtl/cr_rsp_shifter.sv
module cr_rsp_shifter #(
  parameter int RSP_MAX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample,
  input  logic               sdi,
  input  logic               fin,
  output logic               rsp_valid,
  output logic [RSP_MAX-1:0] rsp_data
);
  logic [RSP_MAX-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (sample) acc <= {acc[RSP_MAX-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) rsp_data <= acc;
    end
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/cr_serial_master.sv
module cr_serial_master #(
  parameter int CMD_W   = 8,
  parameter int RSP_MIN = 4,
  parameter int RSP_MAX = 16,
  parameter int LEN_W   = 5,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_byte,
  input  logic [LEN_W-1:0]   rsp_len,
  input  logic [DIV_W-1:0]   sclk_div,
  output logic               busy,
  output logic               rsp_valid,
  output logic [RSP_MAX-1:0] rsp_data,
  output logic               ser_clk,
  output logic               ser_sel_n,
  output logic               ser_out,
  input  logic               ser_in
);
  localparam int HC_W = $clog2(2 * (CMD_W + 1 + RSP_MAX) + 1);

  logic             accept, launch, sample, fin, tick;
  logic [HC_W-1:0]  hcnt;
  logic [LEN_W-1:0] nlen;
  logic [DIV_W-1:0] half_len;

  assign cmd_ready = !busy;

  cr_frame_seq #(
    .CMD_W(CMD_W), .RSP_MIN(RSP_MIN), .RSP_MAX(RSP_MAX),
    .LEN_W(LEN_W), .DIV_W(DIV_W), .HC_W(HC_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rsp_len(rsp_len),
    .sclk_div(sclk_div), .tick(tick), .accept(accept), .busy(busy),
    .launch(launch), .sample(sample), .fin(fin), .hcnt(hcnt), .nlen(nlen),
    .half_len(half_len), .sclk(ser_clk), .sel_n(ser_sel_n)
  );

  cr_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
    .half_len(half_len), .tick(tick)
  );

  cr_cmd_shifter #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(accept), .cmd(cmd_byte),
    .shift(launch), .clear(fin), .sdo(ser_out)
  );

  cr_rsp_shifter #(.RSP_MAX(RSP_MAX)) u_rsp (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample),
    .sdi(ser_in), .fin(fin), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assert_out_quiet_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hcnt >= HC_W'(2 * CMD_W)) |-> !ser_out);
  assert_idle_out_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);
  assert_upper_bits_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_data >> nlen) == '0));
  assert_reply_with_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ser_sel_n && !ser_clk));
endmodule

// File: tb/cr_serial_master_tb.sv
module cr_serial_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_byte = '0;
  logic [4:0]  rsp_len = 5'd8;
  logic [7:0]  sclk_div = 8'd2;
  logic        busy, rsp_valid, ser_clk, ser_sel_n, ser_out;
  logic [15:0] rsp_data;
  logic        ser_in = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cr_serial_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rsp_len(rsp_len), .sclk_div(sclk_div), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ser_clk(ser_clk),
    .ser_sel_n(ser_sel_n), .ser_out(ser_out), .ser_in(ser_in)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(ser_clk == 1'b0, "R1 idle ser_clk", int'(ser_clk), 0);
    check(ser_sel_n == 1'b1, "R1 idle ser_sel_n", int'(ser_sel_n), 1);
    check(ser_out == 1'b0, "R1 idle ser_out", int'(ser_out), 0);
    check(busy == 1'b0 && cmd_ready == 1'b1, "R1 idle busy/ready",
          int'({busy, cmd_ready}), 1);
    check(rsp_valid == 1'b0, "R1 idle rsp_valid", int'(rsp_valid), 0);
  endtask

  // Runs one frame acting as the slave, and checks every rule of it
  task automatic run_frame(input logic [7:0] cmd, input logic [4:0] len,
                           input logic [7:0] div, input logic [15:0] reply,
                           input bit poke, input string tag);
    int n = (len < 5'd4) ? 4 : ((len > 5'd16) ? 16 : int'(len));
    int h = (int'(div) / 2 == 0) ? 1 : int'(div) / 2;
    int exp_cyc = (18 + 2 * n) * h;
    logic [15:0] exp_rsp = reply & 16'((32'd1 << n) - 1);
    logic [7:0] cap = '0;
    logic [15:0] got = '0;
    int rises = 0, idx = 0, done_idx = -1, r1 = -1, r2 = -1;
    bit prev = 0, mosi_bad = 0, sel_bad = 0, done = 0, idle_ok = 1;

    @(negedge clk);
    check(cmd_ready == 1'b1, {"R2 ready before start ", tag}, int'(cmd_ready), 1);
    cmd_byte = cmd; rsp_len = len; sclk_div = div; cmd_valid = 1'b1; ser_in = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(ser_sel_n == 1'b0 && busy && !cmd_ready, {"R2 select/busy at accept ", tag},
          int'({ser_sel_n, busy, cmd_ready}), 2);
    check(ser_out == cmd[7], {"R4 first bit at accept ", tag}, int'(ser_out), int'(cmd[7]));
    while (!done && idx < exp_cyc + 40) begin
      if (poke && idx == 5) begin cmd_valid = 1'b1; cmd_byte = ~cmd; rsp_len = 5'd16; end
      if (poke && idx == 7) begin cmd_valid = 1'b0; end
      if (ser_clk && !prev) begin
        rises++;
        if (rises <= 8) cap = {cap[6:0], ser_out};
        if (rises == 1) r1 = idx;
        if (rises == 2) r2 = idx;
        // bit for the following rise; ones outside the reply window
        if (rises + 1 >= 10 && rises + 1 <= 9 + n) ser_in = reply[n - 1 - (rises + 1 - 10)];
        else ser_in = 1'b1;
      end
      if ((rises > 8 || (rises == 8 && !ser_clk)) && ser_out) mosi_bad = 1;
      if (rsp_valid) begin
        done = 1; done_idx = idx; got = rsp_data;
        check(ser_sel_n && !ser_clk && !busy, {"R9 lines idle at reply ", tag},
              int'({ser_sel_n, ser_clk, busy}), 4);
      end else if (ser_sel_n) sel_bad = 1;
      prev = ser_clk;
      @(negedge clk);
      idx++;
    end
    check(r1 == h, {"R2 first rise half period after accept ", tag}, r1, h);
    check(r2 - r1 == 2 * h, {"R3 serial period ", tag}, r2 - r1, 2 * h);
    check(cap == (poke ? cmd : cmd), {"R4 command bits MSB first ", tag}, int'(cap), int'(cmd));
    check(!mosi_bad, {"R6 ser_out low after command ", tag}, int'(mosi_bad), 0);
    check(!sel_bad, {"R2 select held low ", tag}, int'(sel_bad), 0);
    check(rises == 9 + n, {"R7 rising edge count ", tag}, rises, 9 + n);
    check(done_idx == exp_cyc, {"R9 frame length in cycles ", tag}, done_idx, exp_cyc);
    check(got == exp_rsp, {"R7 R8 R5 reply value ", tag}, int'(got), int'(exp_rsp));
    check(rsp_valid == 1'b0, {"R9 reply pulse one cycle ", tag}, int'(rsp_valid), 0);
    if (poke) begin
      for (int i = 0; i < 30; i++) begin
        if (!ser_sel_n || rsp_valid || busy) idle_ok = 0;
        @(negedge clk);
      end
      check(idle_ok, {"R10 no frame from request while busy ", tag}, int'(idle_ok), 1);
    end
  endtask

  task automatic test_basic();        run_frame(8'hA5, 5'd8, 8'd4, 16'h003C, 0, "basic"); endtask
  task automatic test_short_fast();   run_frame(8'h81, 5'd4, 8'd2, 16'h000A, 0, "len4 div2"); endtask
  task automatic test_long_slow();    run_frame(8'h3E, 5'd16, 8'd6, 16'hBEEF, 0, "len16 div6"); endtask
  task automatic test_clamp_low();    run_frame(8'h5A, 5'd1, 8'd4, 16'hFFF5, 0, "R8 clamp low"); endtask
  task automatic test_clamp_high();   run_frame(8'hC3, 5'd31, 8'd2, 16'h1234, 0, "R8 clamp high"); endtask
  task automatic test_odd_div();      run_frame(8'h0F, 5'd5, 8'd7, 16'h0013, 0, "R3 odd divider"); endtask
  task automatic test_zero_div();     run_frame(8'hF0, 5'd6, 8'd0, 16'h002D, 0, "R3 zero divider"); endtask
  task automatic test_busy_ignore();  run_frame(8'h69, 5'd7, 8'd4, 16'h0055, 1, "R10 busy request"); endtask
  task automatic test_back_to_back();
    run_frame(8'h12, 5'd9, 8'd2, 16'h01A7, 0, "b2b first");
    run_frame(8'hED, 5'd12, 8'd2, 16'h0C3A, 0, "b2b second");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_basic();
    test_short_fast();
    test_long_slow();
    test_clamp_low();
    test_clamp_high();
    test_odd_div();
    test_zero_div();
    test_busy_ignore();
    test_back_to_back();
    test_reset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule